// File: doc/BRIEF.md
# Extended Match Channel Array

This block holds eight match channels, numbered 0 to 7 here. Each channel owns a counter, a match value and a control word. A counter advances by one on every clock cycle in which its chosen tick-enable input is high. The channels form fixed groups. Channels 0 to 3 share the counter of channel 0. Channels 4 and 5 share the counter of channel 4, and channels 6 and 7 share the counter of channel 6. A channel can leave its group and use its own counter. Each channel compares the counter it follows against its match value and raises a match event when they meet. Channels can run one-shot or periodic, and a match can return the followed counter to zero.

Match events pass through a per-channel enable into one shared status word. A single interrupt line stays high while any status bit is set. Software reaches every register through a simple single-cycle bus. Every access is accepted in the cycle it is presented, so the bus has no back-pressure and no ready signal. Reads are combinational from the registers. Reading the counter of channel 5 or 7 can also capture the counter of the channel just below it into a snapshot register.

Address map: `bus_addr[4:3]` selects the register kind and `bus_addr[2:0]` selects the channel. The kinds are 0 = counter, 1 = match, 2 = control and 3 = shared. In the shared kind, channel field 0 is the status word, 1 is the enable word and 2 is the snapshot.

Top module: `emx_match_array`

## Requirements
- R1: Channels 0 to 3 follow the counter of channel 0. Channels 4 and 5 follow channel 4, and channels 6 and 7 follow channel 6. Control bit 7 set makes a channel follow its own counter instead.
- R2: Control bits 2:0 give a source index s. Counter k advances by one in each cycle in which `tick_en[s]` is high. s = 0 keeps the counter stopped whatever `tick_en` holds.
- R3: A control write updates the channel's source index only when bit 7 of the written word is set or the channel leads a group (channels 0, 4 and 6). Otherwise the previous source index stays in force.
- R4: Channels 0 to 3 keep control bits 7:0, and higher bits read back as 0. Channels 4 to 7 keep bits 9:0. On channels 4 to 7, a written bit 8 forces the source index to 0.
- R5: When control bit 3 is set, a match makes the followed counter 0 on that tick instead of the matching value.
- R6: A write to a channel's match or control register arms the channel. A match occurs on a tick that brings the followed counter to the match value while the channel is armed. With control bit 6 clear, the match disarms the channel. With bit 6 set, the channel stays armed.
- R7: A bus read of the counter of channel 5 or 7 with that channel's control bit 9 set copies the counter of channel 4 or 6 into the snapshot register. Reads of other counters leave the snapshot unchanged.
- R8: A match sets status bit c when enable bit c is set, and is dropped otherwise. Writing the status word clears the bits written as 1. `irq_out` is high exactly while some status bit is set, so it falls only when a clearing write leaves no bit set.
- R9: A counter write loads that counter. A match write replaces the compare value. Both values are visible on read in the next cycle.
- R10: After reset, all counters, match values, control words, status, enable and snapshot are 0, and every counter is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe, accepted every cycle |
| bus_rd | input | 1 | Register read strobe (only used for snapshot capture) |
| bus_addr | input | 5 | {kind[1:0], channel[2:0]} |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from the registers |
| tick_en | input | NSRC | Per-source tick enables; index 0 is unused |
| irq_out | output | 1 | Combined interrupt |

## Verification
The hardest condition to reach from the ports is a source index that stayed in force after the control word changed. That index only matters once the channel has left its group. The bench reaches it by writing an own-counter control word, then a group-following one with a different source. It then shows that the channel's own counter still advances on the first source only. A second hard case is one-shot disarm, which shows nothing on its own. The bench brings the counter back below the match value with a plain counter write, so the channel is not rearmed. It then ticks through the match again and expects the status word to stay clear.

// File: rtl/emx_pkg.sv
package emx_pkg;
  localparam int NCH   = 8;
  localparam int CTRLW = 10;

  localparam int CB_OWN      = 7;
  localparam int CB_PERIODIC = 6;
  localparam int CB_ZERO     = 3;
  localparam int CB_STOP     = 8;
  localparam int CB_SNAP     = 9;

  typedef enum logic [1:0] {
    K_CNT   = 2'd0,
    K_MATCH = 2'd1,
    K_CTRL  = 2'd2,
    K_MISC  = 2'd3
  } emx_kind_e;

  function automatic int leader_of(int idx);
    return (idx < 4) ? 0 : (idx / 2) * 2;
  endfunction
endpackage

// File: rtl/emx_counter.sv
module emx_counter #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          clr,
  output logic [DW-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (load)  cnt <= load_val;
    else if (clr)   cnt <= '0;
    else if (adv)   cnt <= cnt + DW'(1);
  end

  AST_CNT_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv && !clr) |=> $stable(cnt)); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val))); // R9
endmodule

// File: rtl/emx_channel.sv
module emx_channel
  import emx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int IDX  = 0,
  parameter int SRCW = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             match_wr,
  input  logic [DW-1:0]    wdata,
  input  logic             sel_adv,
  input  logic             sel_load,
  input  logic [DW-1:0]    sel_cnt,
  output logic [CTRLW-1:0] ctrl,
  output logic [SRCW-1:0]  src,
  output logic [DW-1:0]    match_val,
  output logic             hit,
  output logic             clr_req
);
  localparam int  KEEPW  = (IDX >= 4) ? 10 : 8;
  localparam bit  LEADER = (leader_of(IDX) == IDX);
  localparam logic [CTRLW-1:0] CMASK = CTRLW'((1 << KEEPW) - 1);

  logic armed;
  logic take_src;

  assign take_src = wdata[CB_OWN] || LEADER;
  assign hit      = armed && sel_adv && !sel_load && ((sel_cnt + DW'(1)) == match_val);
  assign clr_req  = hit && ctrl[CB_ZERO];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl      <= '0;
      src       <= '0;
      match_val <= '0;
      armed     <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl <= wdata[CTRLW-1:0] & CMASK;
        if (take_src) begin
          if (KEEPW == 10 && wdata[CB_STOP]) src <= '0;
          else                               src <= wdata[SRCW-1:0];
        end
      end
      if (match_wr) match_val <= wdata;
      if (ctrl_wr || match_wr)              armed <= 1'b1;
      else if (hit && !ctrl[CB_PERIODIC])   armed <= 1'b0;
    end
  end

  AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !ctrl[CB_PERIODIC] && !ctrl_wr && !match_wr) |=> !armed); // R6
  AST_PERIODIC_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ctrl[CB_PERIODIC]) |=> armed); // R6
endmodule

// File: rtl/emx_irq.sv
module emx_irq #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] hit,
  input  logic           st_wr,
  input  logic           en_wr,
  input  logic [NCH-1:0] wbits,
  output logic [NCH-1:0] status,
  output logic [NCH-1:0] enable,
  output logic           irq
);
  logic [NCH-1:0] clr_bits;
  assign clr_bits = st_wr ? wbits : '0;
  assign irq      = |status;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= (status & ~clr_bits) | (hit & enable);
      if (en_wr) enable <= wbits;
    end
  end

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(hit & enable)) |=> irq); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !st_wr) |=> irq); // R8
endmodule

// File: rtl/emx_match_array.sv
module emx_match_array
  import emx_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [4:0]      bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] tick_en,
  output logic            irq_out
);
  localparam int SRCW = $clog2(NSRC);
  localparam int CHW  = $clog2(NCH);

  emx_kind_e      kind;
  logic [CHW-1:0] chn;
  assign kind = emx_kind_e'(bus_addr[4:3]);
  assign chn  = bus_addr[CHW-1:0];

  logic [DW-1:0]    cnt     [NCH];
  logic [DW-1:0]    mval    [NCH];
  logic [CTRLW-1:0] ctrl    [NCH];
  logic [SRCW-1:0]  src     [NCH];
  logic [CHW-1:0]   sel_idx [NCH];
  logic [NCH-1:0]   adv, load, clr, hit, clr_req;
  logic [NCH-1:0]   status, enable;
  logic [DW-1:0]    snap;

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      sel_idx[c] = ctrl[c][CB_OWN] ? CHW'(c) : CHW'(leader_of(c));
    end
    for (int k = 0; k < NCH; k++) begin
      clr[k] = 1'b0;
      for (int c = 0; c < NCH; c++) begin
        if (sel_idx[c] == CHW'(k) && clr_req[c]) clr[k] = 1'b1;
      end
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    assign adv[k]  = (src[k] != '0) && tick_en[src[k]];
    assign load[k] = bus_wr && (kind == K_CNT) && (chn == CHW'(k));

    emx_counter #(.DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .adv(adv[k]), .load(load[k]),
      .load_val(bus_wdata), .clr(clr[k]), .cnt(cnt[k])
    );

    emx_channel #(.DW(DW), .IDX(k), .SRCW(SRCW)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .ctrl_wr(bus_wr && (kind == K_CTRL) && (chn == CHW'(k))),
      .match_wr(bus_wr && (kind == K_MATCH) && (chn == CHW'(k))),
      .wdata(bus_wdata),
      .sel_adv(adv[sel_idx[k]]), .sel_load(load[sel_idx[k]]),
      .sel_cnt(cnt[sel_idx[k]]),
      .ctrl(ctrl[k]), .src(src[k]), .match_val(mval[k]),
      .hit(hit[k]), .clr_req(clr_req[k])
    );
  end

  emx_irq #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .st_wr(bus_wr && (kind == K_MISC) && (chn == CHW'(0))),
    .en_wr(bus_wr && (kind == K_MISC) && (chn == CHW'(1))),
    .wbits(bus_wdata[NCH-1:0]),
    .status(status), .enable(enable), .irq(irq_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) snap <= '0;
    else if (bus_rd && (kind == K_CNT) && (chn == CHW'(5) || chn == CHW'(7))
             && ctrl[chn][CB_SNAP])
      snap <= cnt[chn - CHW'(1)];
  end

  always_comb begin
    bus_rdata = '0;
    unique case (kind)
      K_CNT:   bus_rdata = cnt[chn];
      K_MATCH: bus_rdata = mval[chn];
      K_CTRL:  bus_rdata = DW'(ctrl[chn]);
      K_MISC: begin
        if (chn == CHW'(0))      bus_rdata = DW'(status);
        else if (chn == CHW'(1)) bus_rdata = DW'(enable);
        else if (chn == CHW'(2)) bus_rdata = snap;
      end
      default: bus_rdata = '0;
    endcase
  end

  AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(snap)); // R7
endmodule

// File: tb/test_emx_match_array.sv
module test_emx_match_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tick_en = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  emx_match_array i_emx_match_array (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tick_en(tick_en), .irq_out(irq_out)
  );

  // {src, tick mask, tick count, expected count} for channel 0
  localparam logic [31:0] VEC [6] = '{
    {8'd1, 8'h02, 8'd5, 8'd5},
    {8'd1, 8'hFD, 8'd5, 8'd0},
    {8'd3, 8'h08, 8'd4, 8'd4},
    {8'd0, 8'hFF, 8'd4, 8'd0},
    {8'd7, 8'h80, 8'd3, 8'd3},
    {8'd2, 8'h04, 8'd6, 8'd6}
  };

  function automatic logic [4:0] A(int kind, int ch);
    return {2'(kind), 3'(ch)};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(logic [7:0] mask, int n);
    for (int i = 0; i < n; i++) begin
      tick_en = mask;
      @(negedge clk);
      tick_en = '0;
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    @(negedge clk);
    do_reset();

    // R10 reset state
    rd(A(2, 5), v); check("R10 ctrl", v, 0);
    rd(A(0, 3), v); check("R10 counter", v, 0);
    rd(A(3, 2), v); check("R10 snapshot", v, 0);
    check("R10 irq", {31'd0, irq_out}, 0);

    // R2 table of tick sources
    for (int i = 0; i < 6; i++) begin
      wr(A(2, 0), {24'd0, VEC[i][31:24]});
      wr(A(0, 0), 0);
      ticks(VEC[i][23:16], int'(VEC[i][15:8]));
      rd(A(0, 0), v);
      check("R2 source select", v, {24'd0, VEC[i][7:0]});
    end

    // R1 group follow, then own counter
    do_reset();
    wr(A(3, 1), 32'h04);
    wr(A(2, 0), 32'h01);
    wr(A(2, 2), 32'h00);
    wr(A(1, 2), 3);
    ticks(8'h02, 3);
    rd(A(3, 0), v); check("R1 follow leader status", v, 32'h04);
    rd(A(0, 2), v); check("R1 own counter idle", v, 0);
    wr(A(3, 0), 32'h04);
    wr(A(2, 2), 32'h81);
    wr(A(1, 2), 2);
    ticks(8'h02, 2);
    rd(A(3, 0), v); check("R1 own counter match", v, 32'h04);
    rd(A(0, 2), v); check("R1 own counter value", v, 2);

    // R3 source kept without own bit; leader takes it
    do_reset();
    wr(A(2, 1), 32'h82);
    wr(A(2, 1), 32'h03);
    ticks(8'h08, 3);
    rd(A(0, 1), v); check("R3 source kept", v, 0);
    ticks(8'h04, 2);
    rd(A(0, 1), v); check("R3 old source active", v, 2);
    wr(A(2, 4), 32'h01);
    ticks(8'h02, 3);
    rd(A(0, 4), v); check("R3 leader update", v, 3);

    // R4 widths and forced stop
    do_reset();
    wr(A(2, 0), 32'h3FF);
    rd(A(2, 0), v); check("R4 narrow ctrl", v, 32'hFF);
    wr(A(2, 4), 32'h3FF);
    rd(A(2, 4), v); check("R4 wide ctrl", v, 32'h3FF);
    wr(A(2, 6), 32'h101);
    ticks(8'h02, 3);
    rd(A(0, 6), v); check("R4 bit8 stop", v, 0);

    // R5 zero on match + R6 periodic
    do_reset();
    wr(A(3, 1), 32'h40);
    wr(A(2, 6), 32'h49);
    wr(A(1, 6), 3);
    ticks(8'h02, 3);
    rd(A(0, 6), v); check("R5 counter zeroed", v, 0);
    rd(A(3, 0), v); check("R5 match event", v, 32'h40);
    wr(A(3, 0), 32'h40);
    ticks(8'h02, 3);
    rd(A(3, 0), v); check("R6 periodic again", v, 32'h40);

    // R6 one-shot
    do_reset();
    wr(A(3, 1), 32'h20);
    wr(A(2, 5), 32'h81);
    wr(A(1, 5), 2);
    ticks(8'h02, 2);
    rd(A(3, 0), v); check("R6 first match", v, 32'h20);
    wr(A(3, 0), 32'h20);
    wr(A(0, 5), 0);
    ticks(8'h02, 2);
    rd(A(3, 0), v); check("R6 one-shot silent", v, 0);
    check("R6 irq low", {31'd0, irq_out}, 0);

    // R8 enable gating and irq release
    do_reset();
    wr(A(3, 1), 32'h06);
    wr(A(2, 0), 32'h01);
    wr(A(1, 1), 2);
    wr(A(1, 2), 3);
    wr(A(1, 3), 2);
    ticks(8'h02, 3);
    rd(A(3, 0), v); check("R8 status gated", v, 32'h06);
    check("R8 irq set", {31'd0, irq_out}, 1);
    wr(A(3, 0), 32'h02);
    check("R8 irq held", {31'd0, irq_out}, 1);
    wr(A(3, 0), 32'h04);
    check("R8 irq released", {31'd0, irq_out}, 0);

    // R7 snapshot and R9 load/match readback
    do_reset();
    wr(A(0, 4), 32'h55);
    rd(A(0, 4), v); check("R9 counter load", v, 32'h55);
    wr(A(1, 3), 32'hABCD);
    rd(A(1, 3), v); check("R9 match load", v, 32'hABCD);
    wr(A(2, 5), 32'h200);
    rd(A(0, 5), v);
    rd(A(3, 2), v); check("R7 snapshot taken", v, 32'h55);
    wr(A(0, 6), 32'h77);
    rd(A(0, 7), v);
    rd(A(3, 2), v); check("R7 snapshot untouched", v, 32'h55);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule